// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the 32-bit memory offset of a load or store from operands that a decoder has already pulled out of the instruction. It takes a base register value, an index register value, a two-bit scale code, a displacement that is either a short 8-bit field or a full 32-bit word, and a mode code. The mode code selects which operands count towards the sum. The block returns the effective address and a flag that reports an access which is not naturally aligned for its size.

Unaligned accesses are legal. The misalignment flag is advisory and never changes the address. The sum wraps modulo 2^32 and has no overflow indication. A parameter chooses the timing. With it set, the results pass through one output register, and that register clears on reset. With it clear, the results follow the inputs combinationally.

Top module: `ea_gen`

## Requirements
- R1: Mode code 0 (absolute) outputs `disp` as the full 32-bit address, whatever `disp_wide` is set to. The base and index values have no effect.
- R2: Mode code 1 outputs `base` unchanged. Mode code 7 is reserved and behaves the same as mode 1.
- R3: Mode code 2 outputs `base` plus the selected displacement.
- R4: Mode code 3 outputs `base + index`, and mode code 4 outputs `base + index + displacement`. The scale code has no effect in both modes.
- R5: Mode code 5 outputs `base + (index << s)`, and mode code 6 outputs that sum plus the displacement. Here s is the value of the scale code, so codes 00, 01, 10 and 11 multiply the index by 1, 2, 4 and 8.
- R6: When `disp_wide` is 0, the displacement is `disp[7:0]` sign-extended to 32 bits, and `disp[31:8]` has no effect. When `disp_wide` is 1, all 32 bits of `disp` are used.
- R7: All sums wrap modulo 2^32. A carry out of bit 31 is discarded, and there is no overflow output.
- R8: Size code 00 (byte) never raises `misalign`. Size code 01 (halfword) raises it when `ea[0]` is 1. Size codes 10 (word) and 11 (treated as word) raise it when `ea[1:0]` is not 00.
- R9: With `REG_OUT`=1, `ea` and `misalign` show the result of the inputs present at a rising clock edge from that edge until the next one, and both read 0 while `rst_n` is low. With `REG_OUT`=0, both outputs follow the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| mode | input | 3 | Addressing-mode code (0 to 7) |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| scale | input | 2 | Index scale code, shift amount 0 to 3 |
| disp | input | 32 | Displacement, of which the low 8 bits are used when short |
| disp_wide | input | 1 | 1: 32-bit displacement, 0: sign-extended 8-bit |
| size | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| ea | output | 32 | Effective address |
| misalign | output | 1 | Access not naturally aligned for its size |

## Verification
With the default registered output, a vector driven on a falling edge is captured at the next rising edge. Both `ea` and `misalign` are then due at that edge and are read on the falling edge after it. Just before that capturing edge, the bench also checks that the outputs still hold the previous vector's result, which pins the latency at exactly one cycle. The sweep covers every mode, scale code, displacement width and size code, with random operands. It adds corner vectors for the sign extension, for wrap-around past 2^32, and for each pattern of the low two address bits.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW      = 32,
  parameter int SHORT_W = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] index,
  input  logic [1:0]    scale,
  input  logic [AW-1:0] disp,
  input  logic          disp_wide,
  input  logic [1:0]    size,
  output logic [AW-1:0] ea,
  output logic          misalign
);

  localparam int EXT_W = AW - SHORT_W;

  localparam logic [2:0] M_ABS   = 3'd0;
  localparam logic [2:0] M_B     = 3'd1;
  localparam logic [2:0] M_BD    = 3'd2;
  localparam logic [2:0] M_BI    = 3'd3;
  localparam logic [2:0] M_BID   = 3'd4;
  localparam logic [2:0] M_BSI   = 3'd5;
  localparam logic [2:0] M_BSID  = 3'd6;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;

  logic [AW-1:0] disp_x;
  logic [AW-1:0] idx_s;
  logic [AW-1:0] sum;
  logic          mis_c;

  assign disp_x = disp_wide ? disp
                            : {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};

  always_comb begin
    case (scale)
      2'd0:    idx_s = index;
      2'd1:    idx_s = {index[AW-2:0], 1'b0};
      2'd2:    idx_s = {index[AW-3:0], 2'b00};
      default: idx_s = {index[AW-4:0], 3'b000};
    endcase
  end

  always_comb begin
    case (mode)
      M_ABS:   sum = disp;
      M_BD:    sum = base + disp_x;
      M_BI:    sum = base + index;
      M_BID:   sum = base + index + disp_x;
      M_BSI:   sum = base + idx_s;
      M_BSID:  sum = base + idx_s + disp_x;
      default: sum = base;
    endcase
  end

  always_comb begin
    case (size)
      SZ_BYTE: mis_c = 1'b0;
      SZ_HALF: mis_c = sum[0];
      default: mis_c = |sum[1:0];
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ea       <= '0;
          misalign <= 1'b0;
        end else begin
          ea       <= sum;
          misalign <= mis_c;
        end
      end

      p_abs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_ABS) |=> (ea == $past(disp)));
      p_base_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_B || mode == 3'd7) |=> (ea == $past(base)));
      p_short_disp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_BD && !disp_wide) |=>
          (ea == $past(base) + {{EXT_W{$past(disp[SHORT_W-1])}}, $past(disp[SHORT_W-1:0])}));
      p_byte_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_BYTE) |=> !misalign);
      p_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_HALF) |=> (misalign == ea[0]));
      p_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (size[1]) |=> (misalign == (ea[1:0] != 2'b00)));
    end else begin : g_comb
      assign ea       = sum;
      assign misalign = mis_c;

      p_abs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_ABS) |-> (ea == disp));
      p_base_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_B || mode == 3'd7) |-> (ea == base));
      p_byte_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_BYTE) |-> !misalign);
      p_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (size[1]) |-> (misalign == (ea[1:0] != 2'b00)));
    end
  endgenerate

endmodule

// File: tb/ea_gen_bench.sv
module ea_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = '0;
  logic [31:0] base = '0;
  logic [31:0] index = '0;
  logic [1:0]  scale = '0;
  logic [31:0] disp = '0;
  logic        disp_wide = 1'b0;
  logic [1:0]  size = '0;
  logic [31:0] ea;
  logic        misalign;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] prev_ea = '0;
  logic        prev_mis = 1'b0;

  always #10 clk = ~clk;

  ea_gen u_ea_gen (
    .clk(clk), .rst_n(rst_n), .mode(mode), .base(base), .index(index),
    .scale(scale), .disp(disp), .disp_wide(disp_wide), .size(size),
    .ea(ea), .misalign(misalign)
  );

  function automatic logic [31:0] ref_ea(input logic [2:0] m, input logic [31:0] b,
      input logic [31:0] i, input logic [1:0] s, input logic [31:0] d, input logic w);
    longint unsigned dv, iv, tot;
    dv = w ? longint'(d) : longint'(unsigned'(32'($signed(d[7:0]))));
    iv = longint'(i) * (longint'(1) << s);
    case (m)
      3'd0: tot = longint'(d);
      3'd2: tot = longint'(b) + dv;
      3'd3: tot = longint'(b) + longint'(i);
      3'd4: tot = longint'(b) + longint'(i) + dv;
      3'd5: tot = longint'(b) + iv;
      3'd6: tot = longint'(b) + iv + dv;
      default: tot = longint'(b);
    endcase
    return tot[31:0];
  endfunction

  function automatic logic ref_mis(input logic [31:0] a, input logic [1:0] z);
    if (z == 2'b00) return 1'b0;
    if (z == 2'b01) return a[0];
    return (a % 4) != 0;
  endfunction

  function automatic string tag_of(input logic [2:0] m, input logic w);
    case (m)
      3'd0: return "R1";
      3'd1, 3'd7: return "R2";
      3'd2: return w ? "R3" : "R3/R6";
      3'd3, 3'd4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic apply(input logic [2:0] m, input logic [31:0] b, input logic [31:0] i,
      input logic [1:0] s, input logic [31:0] d, input logic w, input logic [1:0] z,
      input string tag);
    logic [31:0] e_ea;
    logic        e_mis;
    e_ea  = ref_ea(m, b, i, s, d, w);
    e_mis = ref_mis(e_ea, z);
    mode = m; base = b; index = i; scale = s; disp = d; disp_wide = w; size = z;
    #9;
    n_vec++;
    if (ea !== prev_ea || misalign !== prev_mis) begin
      n_bad++;
      $display("FAIL R9 early change: ea=%h mis=%b expected held %h %b", ea, misalign, prev_ea, prev_mis);
    end
    @(negedge clk);
    n_vec++;
    if (ea !== e_ea) begin
      n_bad++;
      $display("FAIL %s ea: mode=%0d got %h expected %h", tag, m, ea, e_ea);
    end
    n_vec++;
    if (misalign !== e_mis) begin
      n_bad++;
      $display("FAIL R8 misalign: size=%0d ea=%h got %b expected %b", z, e_ea, misalign, e_mis);
    end
    prev_ea = e_ea;
    prev_mis = e_mis;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;
    if (ea !== 32'h0 || misalign !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 reset: ea=%h mis=%b expected 00000000 0", ea, misalign);
    end
    rst_n = 1'b1;

    // R1: absolute mode ignores registers and disp_wide
    apply(3'd0, 32'hDEAD_BEEF, 32'h1234_5678, 2'd3, 32'h8000_0081, 1'b0, 2'b10, "R1");
    // R6: short displacement sign extension, upper bits ignored
    apply(3'd2, 32'h0000_1000, 32'h0, 2'd0, 32'hFFFF_FF80, 1'b0, 2'b00, "R6");
    apply(3'd2, 32'h0000_1000, 32'h0, 2'd0, 32'h1234_567F, 1'b0, 2'b00, "R6");
    apply(3'd2, 32'h0000_1000, 32'h0, 2'd0, 32'h1234_5680, 1'b1, 2'b00, "R6");
    // R7: wrap modulo 2^32
    apply(3'd2, 32'hFFFF_FFFF, 32'h0, 2'd0, 32'h0000_0001, 1'b1, 2'b10, "R7");
    apply(3'd6, 32'hF000_0000, 32'h2000_0000, 2'd3, 32'hFFFF_FFFF, 1'b1, 2'b10, "R7");
    // R4: scale ignored in unscaled modes
    apply(3'd4, 32'h100, 32'h10, 2'd3, 32'h4, 1'b0, 2'b10, "R4");
    // R8: every low-bit pattern for every size
    for (int a = 0; a < 4; a++)
      for (int z = 0; z < 4; z++)
        apply(3'd1, 32'h4000_0000 + a, 32'h0, 2'd0, 32'h0, 1'b0, 2'(z), "R8");

    // R1-style sweep: all modes, scales, widths and sizes with random operands
    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 2; w++)
          for (int z = 0; z < 4; z++)
            for (int r = 0; r < 4; r++)
              apply(3'(m), $urandom, $urandom, 2'(s), $urandom, 1'(w), 2'(z), tag_of(3'(m), 1'(w)));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule